// File: doc/BRIEF.md
# Flash Dummy-Phase Snooper for Software-Driven SPI Transfers

This block sits between a software write port and the byte shifter of an SPI flash controller that is in user mode, where software builds every flash command by hand: opcode, address and payload. After each chip-select assertion it reads the first byte software writes as a flash opcode and looks up how many dummy bytes that opcode needs. It then counts the command and address bytes that follow. When the next write arrives after the address phase, the block sends the required dummy bytes to the shifter itself, using a programmable fill byte. It discards the write software meant as its own dummy, and then stops snooping until the next chip-select assertion.

Opcodes that need no dummies, and opcodes it does not recognise, switch snooping off at once, so that traffic flows unchanged. Each accepted write of one to four bytes is sent to the shifter least significant byte first, one byte per ready handshake. The write port stalls while any byte is still waiting to go out.

Top module: `spi_dummy_snoop`

## Requirements
- R1: While reset is asserted and right after it is released, `sh_valid` and `wr_drop` are low, `wr_ready` is high and snooping is off, so a write with no chip-select event is forwarded unchanged.
- R2: While snooping is off, an accepted write of `wr_size` bytes (1 to 4) produces exactly `wr_size` shifter bytes taken from `wr_data`, bits [7:0] first and then upward, with no `wr_drop`.
- R3: After a chip-select assertion, the first accepted write supplies the opcode in `wr_data[7:0]` and is always forwarded. If that opcode needs zero dummies or is not in the table of R4, snooping turns off and every later write is forwarded until the next assertion.
- R4: Opcode to dummy units: 0x0B, 0x3B, 0x3C, 0x6B, 0x6C give 1; 0x0C, 0xBB, 0xBC give 2; 0xEB, 0xEC give 4; 0x02, 0x03, 0x12, 0x13, 0x32, 0x34, 0xA2 and every other value give 0. Each unit is 8 dummy bytes.
- R5: Every accepted write while snooping is on advances the byte index by `wr_size`, starting from 0 at assertion. The dummy phase is reached when the index is at least 4 with `addr4_mode` low, or at least 5 with `addr4_mode` high.
- R6: A write accepted in the dummy phase is dropped: none of its bytes reach the shifter and `wr_drop` is high for one cycle, the cycle after acceptance. In its place units×8 bytes equal to the `dummy_byte` value sampled at acceptance go out, and then snooping is off.
- R7: Bytes leave at one per cycle in which `sh_valid` and `sh_ready` are both high. `wr_ready` is low whenever a byte, payload or dummy, is still pending.
- R8: A chip-select deassertion turns snooping off and clears the pending dummy count, so that later writes are forwarded, including a write that would otherwise have hit the dummy phase.
- R9: When a chip-select event and an accepted write fall in the same cycle, the write is forwarded or dropped according to the state before the event, and the index and pending count take the values the event sets.
- R10: While `sh_valid` is high and `sh_ready` is low, `sh_valid` stays high and `sh_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_evt_valid | input | 1 | One-cycle chip-select event strobe |
| cs_evt_assert | input | 1 | Event kind: 1 assert, 0 deassert |
| wr_valid | input | 1 | Software write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_data | input | 32 | Write payload, lowest byte first on the wire |
| wr_size | input | 3 | Number of valid bytes, 1 to 4 |
| addr4_mode | input | 1 | High selects 4-byte flash addressing |
| dummy_byte | input | 8 | Fill value for inserted dummy bytes |
| sh_valid | output | 1 | Byte offered to the shifter |
| sh_data | output | 8 | Byte toward the shifter |
| sh_ready | input | 1 | Shifter takes the byte this cycle |
| wr_drop | output | 1 | Pulse marking a write swallowed in the dummy phase |

## Verification
The two actions that can share a cycle are a chip-select event and the acceptance of a write. Neither side stalls the other, so the bench raises the event strobe and a write request in the same cycle while the port is idle. It does this in three states: at the dummy threshold with a deassertion, with snooping off and an assertion, and right after an opcode with a repeated assertion. It judges each case by the exact bytes on the shifter port and the drop pulse. It then checks the next writes, which show whether the index and pending count took the values the event sets.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int IDX_W        = 8;
  localparam logic [IDX_W-1:0] IDX_OFF   = 8'hFF;
  localparam logic [IDX_W-1:0] IDX_START = 8'h00;
  localparam int NARROW_ADDR  = 3;
  localparam int WIDE_ADDR    = 4;
  localparam int UNIT_W       = 3;

  // Dummy units (groups of eight bytes) required by a flash opcode.
  function automatic logic [UNIT_W-1:0] dummy_units(input logic [7:0] op);
    logic [UNIT_W-1:0] u;
    case (op)
      8'hEB, 8'hEC:                      u = 3'd4;
      8'h0C, 8'hBB, 8'hBC:               u = 3'd2;
      8'h0B, 8'h3B, 8'h3C, 8'h6B, 8'h6C: u = 3'd1;
      default:                           u = 3'd0;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/snoop_opcode_decode.sv
module snoop_opcode_decode
  import snoop_pkg::*;
(
  input  logic [7:0]        opcode,
  output logic [UNIT_W-1:0] units
);
  always_comb begin
    units = dummy_units(opcode);
  end
endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker
  import snoop_pkg::*;
#(
  parameter int SIZE_W     = 3,
  parameter int DCNT_W     = 6,
  parameter int UNIT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_evt_valid,
  input  logic              cs_evt_assert,
  input  logic              accept,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              addr4_mode,
  input  logic [UNIT_W-1:0] units,
  output logic              drop_now,
  output logic [DCNT_W-1:0] dummy_cnt,
  output logic              wr_drop
);
  localparam logic [IDX_W-1:0] THR_NARROW = IDX_W'(NARROW_ADDR + 1);
  localparam logic [IDX_W-1:0] THR_WIDE   = IDX_W'(WIDE_ADDR + 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DCNT_W-1:0] pend_q, pend_d;
  logic              idx_en, pend_en;
  logic              drop_q;
  logic              snoop_on, at_opcode, at_dummy;
  logic [IDX_W-1:0]  thr, idx_adv;

  always_comb begin
    snoop_on  = (idx_q != IDX_OFF);
    at_opcode = snoop_on && (idx_q == IDX_START);
    thr       = addr4_mode ? THR_WIDE : THR_NARROW;
    at_dummy  = snoop_on && !at_opcode && (idx_q >= thr);
    idx_adv   = idx_q + IDX_W'(wr_size);
    drop_now  = accept && at_dummy;
    dummy_cnt = pend_q;
  end

  // Next-state: a chip-select event overrides what the write would set.
  always_comb begin
    idx_d   = idx_q;
    pend_d  = pend_q;
    idx_en  = 1'b0;
    pend_en = 1'b0;
    if (accept && snoop_on) begin
      idx_en = 1'b1;
      if (at_opcode) begin
        if (units == '0) begin
          idx_d = IDX_OFF;
        end else begin
          idx_d   = idx_adv;
          pend_d  = DCNT_W'(units) * DCNT_W'(UNIT_BYTES);
          pend_en = 1'b1;
        end
      end else if (at_dummy) begin
        idx_d   = IDX_OFF;
        pend_d  = '0;
        pend_en = 1'b1;
      end else begin
        idx_d = idx_adv;
      end
    end
    if (cs_evt_valid) begin
      idx_en  = 1'b1;
      idx_d   = cs_evt_assert ? IDX_START : IDX_OFF;
      pend_en = 1'b1;
      pend_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= IDX_OFF;
      pend_q <= '0;
      drop_q <= 1'b0;
    end else begin
      if (idx_en)  idx_q  <= idx_d;
      if (pend_en) pend_q <= pend_d;
      drop_q <= drop_now;
    end
  end

  assign wr_drop = drop_q;
endmodule

// File: rtl/snoop_byte_emitter.sv
module snoop_byte_emitter #(
  parameter int DATA_BYTES = 4,
  parameter int SIZE_W     = 3,
  parameter int DCNT_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_data,
  input  logic [8*DATA_BYTES-1:0] data,
  input  logic [SIZE_W-1:0]       size,
  input  logic                    load_dummy,
  input  logic [DCNT_W-1:0]       dummy_cnt,
  input  logic [7:0]              dummy_val,
  input  logic                    sh_ready,
  output logic                    sh_valid,
  output logic [7:0]              sh_data,
  output logic                    busy
);
  localparam int DATA_W = 8 * DATA_BYTES;

  logic [DATA_W-1:0] buf_q, buf_d;
  logic [SIZE_W-1:0] nbyte_q, nbyte_d;
  logic [DCNT_W-1:0] ndum_q, ndum_d;
  logic [7:0]        dval_q;
  logic              dum_active, fire;
  logic              buf_en, nbyte_en, ndum_en, dval_en;

  always_comb begin
    dum_active = (ndum_q != '0);
    sh_valid   = dum_active || (nbyte_q != '0);
    sh_data    = dum_active ? dval_q : buf_q[7:0];
    busy       = sh_valid;
    fire       = sh_valid && sh_ready;
  end

  always_comb begin
    buf_d    = buf_q;
    nbyte_d  = nbyte_q;
    ndum_d   = ndum_q;
    buf_en   = 1'b0;
    nbyte_en = 1'b0;
    ndum_en  = 1'b0;
    dval_en  = 1'b0;
    if (load_data) begin
      buf_d    = data;
      nbyte_d  = size;
      buf_en   = 1'b1;
      nbyte_en = 1'b1;
    end else if (load_dummy) begin
      ndum_d  = dummy_cnt;
      ndum_en = 1'b1;
      dval_en = 1'b1;
    end else if (fire) begin
      if (dum_active) begin
        ndum_d  = ndum_q - 1'b1;
        ndum_en = 1'b1;
      end else begin
        buf_d    = buf_q >> 8;
        nbyte_d  = nbyte_q - 1'b1;
        buf_en   = 1'b1;
        nbyte_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      nbyte_q <= '0;
      ndum_q  <= '0;
      dval_q  <= '0;
    end else begin
      if (buf_en)   buf_q   <= buf_d;
      if (nbyte_en) nbyte_q <= nbyte_d;
      if (ndum_en)  ndum_q  <= ndum_d;
      if (dval_en)  dval_q  <= dummy_val;
    end
  end
endmodule

// File: rtl/spi_dummy_snoop.sv
module spi_dummy_snoop
  import snoop_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int MAX_UNITS  = 4,
  parameter int UNIT_BYTES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cs_evt_valid,
  input  logic                             cs_evt_assert,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic [8*DATA_BYTES-1:0]          wr_data,
  input  logic [$clog2(DATA_BYTES+1)-1:0]  wr_size,
  input  logic                             addr4_mode,
  input  logic [7:0]                       dummy_byte,
  output logic                             sh_valid,
  output logic [7:0]                       sh_data,
  input  logic                             sh_ready,
  output logic                             wr_drop
);
  localparam int SIZE_W = $clog2(DATA_BYTES + 1);
  localparam int DCNT_W = $clog2(MAX_UNITS * UNIT_BYTES + 1);

  logic              busy, accept, drop_now;
  logic [UNIT_W-1:0] units;
  logic [DCNT_W-1:0] dummy_cnt;

  assign wr_ready = !busy;
  assign accept   = wr_valid && wr_ready;

  snoop_opcode_decode u_dec (
    .opcode (wr_data[7:0]),
    .units  (units)
  );

  snoop_tracker #(
    .SIZE_W     (SIZE_W),
    .DCNT_W     (DCNT_W),
    .UNIT_BYTES (UNIT_BYTES)
  ) u_trk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_evt_valid  (cs_evt_valid),
    .cs_evt_assert (cs_evt_assert),
    .accept        (accept),
    .wr_size       (wr_size),
    .addr4_mode    (addr4_mode),
    .units         (units),
    .drop_now      (drop_now),
    .dummy_cnt     (dummy_cnt),
    .wr_drop       (wr_drop)
  );

  snoop_byte_emitter #(
    .DATA_BYTES (DATA_BYTES),
    .SIZE_W     (SIZE_W),
    .DCNT_W     (DCNT_W)
  ) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_data  (accept && !drop_now),
    .data       (wr_data),
    .size       (wr_size),
    .load_dummy (drop_now),
    .dummy_cnt  (dummy_cnt),
    .dummy_val  (dummy_byte),
    .sh_ready   (sh_ready),
    .sh_valid   (sh_valid),
    .sh_data    (sh_data),
    .busy       (busy)
  );
endmodule

// File: rtl/spi_dummy_snoop_checker.sv
module spi_dummy_snoop_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ready,
  input logic       sh_valid,
  input logic       sh_ready,
  input logic [7:0] sh_data,
  input logic       wr_drop,
  input logic [7:0] dummy_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sh_valid && !wr_drop && wr_ready)
        else $error("R1: outputs not idle in reset");
    end
  end

  assert_stall_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid |-> !wr_ready);

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_valid |-> wr_ready);

  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_data)));

  assert_drop_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> (sh_valid && sh_data == $past(dummy_byte)));

  assert_drop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> !wr_drop);
endmodule

bind spi_dummy_snoop spi_dummy_snoop_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready   (wr_ready),
  .sh_valid   (sh_valid),
  .sh_ready   (sh_ready),
  .sh_data    (sh_data),
  .wr_drop    (wr_drop),
  .dummy_byte (dummy_byte)
);

// File: tb/spi_dummy_snoop_bench.sv
module spi_dummy_snoop_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_evt_valid, cs_evt_assert;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_data;
  logic [2:0]  wr_size;
  logic        addr4_mode;
  logic [7:0]  dummy_byte;
  logic        sh_valid, sh_ready, wr_drop;
  logic [7:0]  sh_data;

  always #5 clk = ~clk;

  spi_dummy_snoop u_spi_dummy_snoop (
    .clk(clk), .rst_n(rst_n), .cs_evt_valid(cs_evt_valid), .cs_evt_assert(cs_evt_assert),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_size(wr_size),
    .addr4_mode(addr4_mode), .dummy_byte(dummy_byte), .sh_valid(sh_valid),
    .sh_data(sh_data), .sh_ready(sh_ready), .wr_drop(wr_drop)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  bit bp_en = 0;

  logic [7:0] log_b [0:63];
  int  log_n;
  bit  drop_seen;
  logic [7:0] exp_b [0:63];
  int  exp_n;
  int  m_idx;
  int  m_pend;
  int  stall_bad = 0;
  int  hold_bad = 0;
  bit  hold_armed = 0;
  logic [7:0] hold_val;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int units_of(input logic [7:0] op);
    if (op == 8'hEB || op == 8'hEC) return 4;
    if (op == 8'h0C || op == 8'hBB || op == 8'hBC) return 2;
    if (op == 8'h0B || op == 8'h3B || op == 8'h3C || op == 8'h6B || op == 8'h6C) return 1;
    return 0;
  endfunction

  // Monitor, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sh_valid && sh_ready && log_n < 64) begin
        log_b[log_n] = sh_data;
        log_n++;
      end
      if (wr_drop) drop_seen = 1;
      if (sh_valid && wr_ready) stall_bad++;
      if (hold_armed && !(sh_valid && sh_data == hold_val)) hold_bad++;
      hold_armed = sh_valid && !sh_ready;
      hold_val   = sh_data;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    sh_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sh_ready = bp_en ? lfsr[0] : 1'b1;
    end
  end

  // Reference model of one accepted write.
  task automatic model_write(input logic [31:0] d, input int sz, output bit drop, output string tag);
    int thr;
    exp_n = 0;
    drop = 0;
    thr = addr4_mode ? 5 : 4;
    tag = "R2";
    if (m_idx != 255) begin
      if (m_idx == 0) begin
        tag = "R3";
        if (units_of(d[7:0]) == 0) m_idx = 255;
        else begin
          m_pend = units_of(d[7:0]) * 8;
          m_idx += sz;
        end
      end else if (m_idx >= thr) begin
        tag = "R6";
        drop = 1;
        for (int i = 0; i < m_pend; i++) begin
          exp_b[exp_n] = dummy_byte;
          exp_n++;
        end
        m_idx = 255;
        m_pend = 0;
      end else begin
        tag = "R5";
        m_idx += sz;
      end
    end
    if (!drop) begin
      for (int i = 0; i < sz; i++) begin
        exp_b[exp_n] = d[8*i +: 8];
        exp_n++;
      end
    end
  endtask

  task automatic model_cs(input bit asrt);
    m_idx = asrt ? 0 : 255;
    m_pend = 0;
  endtask

  // cs_mode: 0 none, 1 assert in the same cycle, 2 deassert in the same cycle
  task automatic do_write(input logic [31:0] d, input int sz, input int cs_mode, input string note);
    bit    drop;
    string tag;
    bit    ok;
    model_write(d, sz, drop, tag);
    if (cs_mode != 0) begin
      model_cs(cs_mode == 1);
      tag = {"R9/", tag};
    end
    log_n = 0;
    drop_seen = 0;
    @(posedge clk); #1;
    wr_valid = 1'b1;
    wr_data = d;
    wr_size = 3'(sz);
    if (cs_mode != 0) begin
      cs_evt_valid = 1'b1;
      cs_evt_assert = (cs_mode == 1);
    end
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    cs_evt_valid = 1'b0;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    ok = (log_n == exp_n) && (drop_seen == drop);
    for (int i = 0; i < exp_n && i < log_n; i++) if (log_b[i] !== exp_b[i]) ok = 0;
    check(ok, {tag, " ", note}, (log_n << 8) | int'(drop_seen), (exp_n << 8) | int'(drop));
  endtask

  task automatic cs_event(input bit asrt);
    @(posedge clk); #1;
    cs_evt_valid = 1'b1;
    cs_evt_assert = asrt;
    @(posedge clk); #1;
    cs_evt_valid = 1'b0;
    model_cs(asrt);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 180000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<180000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [0:5];
    rst_n = 1'b0;
    cs_evt_valid = 0; cs_evt_assert = 0; wr_valid = 0; wr_data = '0; wr_size = 3'd1;
    addr4_mode = 0; dummy_byte = 8'h00;
    m_idx = 255; m_pend = 0; log_n = 0; drop_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sh_valid && wr_ready && !wr_drop, "R1 reset idle", {sh_valid, wr_ready, wr_drop}, 3'b010);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!sh_valid && wr_ready && !wr_drop, "R1 after release", {sh_valid, wr_ready, wr_drop}, 3'b010);

    // R1/R2: snooping off after reset; all sizes pass unchanged
    do_write(32'h0000_00EB, 1, 0, "R1 opcode-like byte after reset");
    for (int s = 1; s <= 4; s++) do_write(32'h4433_2211 + s, s, 0, "R2 size sweep");
    do_write(32'hFFFF_FFFF, 4, 0, "R2 passthrough");

    // R3/R4/R5/R6: every opcode, 3-byte mode, opcode then address then dummy then data
    for (int op = 0; op < 256; op++) begin
      dummy_byte = 8'(op) ^ 8'h5A;
      cs_event(1);
      do_write({24'h0, 8'(op)}, 1, 0, "R4 opcode sweep");
      do_write(32'h00A1_B2C3, 3, 0, "R5 address");
      do_write(32'h0000_00FF, 1, 0, "R6 sw dummy");
      do_write(32'h0000_BEEF, 2, 0, "R3 data after");
      cs_event(0);
    end

    // R5/R7/R10: both address widths, combined opcode+address write, backpressure
    ops[0] = 8'h0B; ops[1] = 8'hEC; ops[2] = 8'h3C; ops[3] = 8'hBB; ops[4] = 8'h13; ops[5] = 8'h6B;
    bp_en = 1;
    for (int a = 0; a < 2; a++) begin
      addr4_mode = a[0];
      for (int k = 0; k < 6; k++) begin
        dummy_byte = 8'hC0 + 8'(k);
        cs_event(1);
        do_write({24'h123456, ops[k]}, 4, 0, "R5 op+addr");
        do_write(32'h0000_0077, 1, 0, "R5 width threshold");
        do_write(32'h0000_0099, 1, 0, "R6 after threshold");
        do_write(32'h0000_0055, 1, 0, "R7 tail");
        cs_event(0);
      end
    end
    bp_en = 0;
    addr4_mode = 0;

    // R8: deassert in mid-address cancels the dummy phase
    dummy_byte = 8'h11;
    cs_event(1);
    do_write(32'h0000_00EB, 1, 0, "R8 opcode");
    do_write(32'h0000_2233, 2, 0, "R8 partial address");
    cs_event(0);
    do_write(32'hDDCC_BBAA, 4, 0, "R8 after deassert");
    do_write(32'h0000_0001, 1, 0, "R8 still off");

    // R9 a: drop and deassert in one cycle
    dummy_byte = 8'h3E;
    cs_event(1);
    do_write(32'h0000_00BB, 1, 0, "R9 setup op");
    do_write(32'h0003_0201, 3, 0, "R9 setup addr");
    do_write(32'h0000_00F0, 1, 2, "R9 drop+deassert");
    do_write(32'h0000_00F1, 1, 0, "R9 after deassert");
    // R9 b: write while off plus assert in one cycle
    do_write(32'h0000_006B, 1, 1, "R9 off+assert");
    do_write(32'h0000_000B, 1, 0, "R9 new opcode");
    do_write(32'h0000_0302, 2, 0, "R9 addr");
    do_write(32'h0000_0004, 1, 0, "R9 addr end");
    do_write(32'h0000_0044, 1, 0, "R9 dropped");
    // R9 c: opcode armed, then re-assert together with a write
    cs_event(1);
    do_write(32'h0000_00EC, 1, 0, "R9 op");
    do_write(32'h0000_00EB, 1, 1, "R9 write+assert");
    do_write(32'h0000_0003, 1, 0, "R9 zero-dummy opcode");
    do_write(32'h0005_0403, 4, 0, "R9 passes");
    cs_event(0);

    check(stall_bad == 0, "R7 no accept while busy", stall_bad, 0);
    check(hold_bad == 0, "R10 byte held under backpressure", hold_bad, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule